// File: doc/BRIEF.md
# ADC Input Channel Sequencer

This block chooses, on every conversion trigger, which analog inputs a multi-channel sample-and-hold converter front end digitizes. It drives a select code for the primary channel (channel 0) and a shared select code for the extra simultaneous channels (1 to 3). It also drives a mask that says which of the four channels take part in the conversion. Two select sets, A and B, can be used in alternation. The primary input of set A can be scanned through a bitmask of enabled inputs.

All configuration inputs are treated as live levels. A one-cycle `cfg_we_i` pulse marks a configuration write, and that write restarts the sequence. Results come out registered. They appear one cycle after an accepted trigger together with a one-cycle `valid_o` strobe. `eos_o` marks the conversion after which the sequence is back at its starting point.

Top module: `adc_chan_seq`

## Requirements
- R1: With `hires_i`=0, `ch_en_o` (bit i = channel i converted) follows `chan_cnt_i`: 2'b00 gives 4'b0001, 2'b01 gives 4'b0011, and 2'b10 or 2'b11 gives 4'b1111.
- R2: With `hires_i`=1, `ch_en_o` is 4'b0001 whatever `chan_cnt_i` holds.
- R3: When `scan_en_i`=1 and `scan_mask_i` is non-zero, successive set-A conversions put on `ch0_sel_o` the indices of the set mask bits in ascending order. After the highest index the sequence wraps to the lowest. The first conversion after reset or after a configuration write uses the lowest set bit.
- R4: With `alt_en_i`=0, every conversion uses set A: `sample_b_o`=0 and `ext_sel_o`=`ext_sel_a_i`. When not scanning, `ch0_sel_o`=`sel_a_pos_i`.
- R5: With `alt_en_i`=1, conversions alternate A, B, A, ..., starting with A. A B conversion gives `sample_b_o`=1, `ch0_sel_o`=`sel_b_pos_i` and `ext_sel_o`=`ext_sel_b_i`. A B conversion never advances the scan position.
- R6: `eos_o`=1 with a valid conversion exactly when that conversion returns the sequence to its start: the next conversion would be set A and, if scanning, would use the lowest set mask bit.
- R7: A configuration write (`cfg_we_i`=1) makes the next conversion a set-A conversion at the lowest set mask bit.
- R8: `valid_o` is high for exactly the one cycle after a clock edge at which a trigger was accepted. All other outputs change only in that cycle and otherwise hold their value.
- R9: When `scan_en_i`=1 and `scan_mask_i` is all zeros, set-A conversions use `sel_a_pos_i`.
- R10: A trigger in the same cycle as `cfg_we_i` is dropped: no `valid_o` follows it.
- R11: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Conversion trigger, one cycle per conversion |
| cfg_we_i | input | 1 | Configuration write pulse; restarts the sequence |
| chan_cnt_i | input | 2 | Channel count code |
| hires_i | input | 1 | High-resolution mode; channel 0 only |
| scan_en_i | input | 1 | Scan the set-A primary input |
| alt_en_i | input | 1 | Alternate between sets A and B |
| scan_mask_i | input | 16 | Inputs visited by the scan |
| sel_a_pos_i | input | 4 | Set-A primary select |
| sel_b_pos_i | input | 4 | Set-B primary select |
| ext_sel_a_i | input | 2 | Set-A select for channels 1 to 3 |
| ext_sel_b_i | input | 2 | Set-B select for channels 1 to 3 |
| ch0_sel_o | output | 4 | Primary channel input select |
| ext_sel_o | output | 2 | Extra channel input select |
| ch_en_o | output | 4 | Channels converted |
| sample_b_o | output | 1 | Conversion used set B |
| valid_o | output | 1 | Conversion strobe |
| eos_o | output | 1 | End of sequence |

## Verification
Scanning is tried with a sparse three-bit mask, with a single-bit mask and with an empty mask. These show ascending order and wrap, the case where the wrap point and the start point coincide, and the fallback to the fixed select. Scanning combined with alternation shows that B conversions do not advance the scan position, and that `eos_o` moves from the highest-input A conversion to the B conversion after it. Configuration writes are issued in the middle of a scan and in the middle of an alternation to show the restart of both the position and the toggle. A write that collides with a trigger checks that the trigger is dropped. Each channel count code is tried with and without high resolution, which separates the count decode from the override.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned N_CH  = 4;
  localparam int unsigned CNT_W = 2;

  typedef enum logic [CNT_W-1:0] {
    CNT_CH0   = 2'b00,
    CNT_CH01  = 2'b01,
    CNT_ALL_A = 2'b10,
    CNT_ALL_B = 2'b11
  } chan_cnt_e;
endpackage

// File: rtl/adc_scan_picker.sv
module adc_scan_picker #(
  parameter int unsigned N_IN  = 16,
  localparam int unsigned SEL_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  mask_i,
  input  logic [SEL_W-1:0] cur_i,
  output logic             any_o,
  output logic [SEL_W-1:0] lowest_o,
  output logic [SEL_W-1:0] highest_o,
  output logic [SEL_W-1:0] next_o
);
  always_comb begin
    lowest_o = '0;
    for (int i = N_IN - 1; i >= 0; i--)
      if (mask_i[i]) lowest_o = SEL_W'(i);
  end

  always_comb begin
    highest_o = '0;
    for (int i = 0; i < N_IN; i++)
      if (mask_i[i]) highest_o = SEL_W'(i);
  end

  // nearest enabled index above cur, else wrap to lowest
  always_comb begin
    next_o = lowest_o;
    for (int i = N_IN - 1; i >= 0; i--)
      if (mask_i[i] && (SEL_W'(i) > cur_i)) next_o = SEL_W'(i);
  end

  assign any_o = |mask_i;
endmodule

// File: rtl/adc_chan_decode.sv
module adc_chan_decode
  import adc_seq_pkg::*;
(
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             hires_i,
  output logic [N_CH-1:0]  en_o
);
  logic [CNT_W-1:0] cnt_eff;

  // high-resolution mode masks the count field to zero
  assign cnt_eff = hires_i ? CNT_W'(CNT_CH0) : cnt_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_en
    if (c == 0) begin : g_prim
      assign en_o[c] = 1'b1;
    end else if (c == 1) begin : g_second
      assign en_o[c] = (cnt_eff != CNT_W'(CNT_CH0));
    end else begin : g_upper
      assign en_o[c] = cnt_eff[CNT_W-1];
    end
  end
endmodule

// File: rtl/adc_seq_state.sv
module adc_seq_state #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             accept_i,
  input  logic             advance_i,
  input  logic             toggle_nx_i,
  input  logic [SEL_W-1:0] ptr_nx_i,
  output logic             toggle_q_o,
  output logic             restart_q_o,
  output logic [SEL_W-1:0] ptr_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      toggle_q_o  <= 1'b0;
      restart_q_o <= 1'b1;
      ptr_q_o     <= '0;
    end else if (restart_i) begin
      toggle_q_o  <= 1'b0;
      restart_q_o <= 1'b1;
    end else if (accept_i) begin
      toggle_q_o <= toggle_nx_i;
      if (advance_i) begin
        ptr_q_o     <= ptr_nx_i;
        restart_q_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned EXT_W = 2,
  localparam int unsigned SEL_W = $clog2(N_IN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] chan_cnt_i,
  input  logic             hires_i,
  input  logic             scan_en_i,
  input  logic             alt_en_i,
  input  logic [N_IN-1:0]  scan_mask_i,
  input  logic [SEL_W-1:0] sel_a_pos_i,
  input  logic [SEL_W-1:0] sel_b_pos_i,
  input  logic [EXT_W-1:0] ext_sel_a_i,
  input  logic [EXT_W-1:0] ext_sel_b_i,
  output logic [SEL_W-1:0] ch0_sel_o,
  output logic [EXT_W-1:0] ext_sel_o,
  output logic [N_CH-1:0]  ch_en_o,
  output logic             sample_b_o,
  output logic             valid_o,
  output logic             eos_o
);
  logic             accept, scan_act, use_b, toggle_nx, eos_nx;
  logic             toggle_q, restart_q, any_en;
  logic [SEL_W-1:0] ptr_q, cur_ptr, lowest, highest, ptr_nx, sel0_nx;
  logic [N_CH-1:0]  en_nx;

  assign accept = trig_i & ~cfg_we_i;

  adc_scan_picker #(.N_IN(N_IN)) picker_i (
    .mask_i    (scan_mask_i),
    .cur_i     (cur_ptr),
    .any_o     (any_en),
    .lowest_o  (lowest),
    .highest_o (highest),
    .next_o    (ptr_nx)
  );

  adc_chan_decode decode_i (
    .cnt_i   (chan_cnt_i),
    .hires_i (hires_i),
    .en_o    (en_nx)
  );

  adc_seq_state #(.SEL_W(SEL_W)) state_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (cfg_we_i),
    .accept_i    (accept),
    .advance_i   (scan_act & ~use_b),
    .toggle_nx_i (toggle_nx),
    .ptr_nx_i    (ptr_nx),
    .toggle_q_o  (toggle_q),
    .restart_q_o (restart_q),
    .ptr_q_o     (ptr_q)
  );

  assign cur_ptr   = restart_q ? lowest : ptr_q;
  assign scan_act  = scan_en_i & any_en;
  assign use_b     = alt_en_i & toggle_q;
  assign toggle_nx = alt_en_i & ~use_b;
  assign sel0_nx   = use_b ? sel_b_pos_i : (scan_act ? cur_ptr : sel_a_pos_i);

  // sequence closes when the next conversion is A at the scan start
  assign eos_nx = ~toggle_nx &
                  (~scan_act | (use_b ? (cur_ptr == lowest) : (cur_ptr == highest)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch0_sel_o  <= '0;
      ext_sel_o  <= '0;
      ch_en_o    <= '0;
      sample_b_o <= 1'b0;
      eos_o      <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= accept;
      if (accept) begin
        ch0_sel_o  <= sel0_nx;
        ext_sel_o  <= use_b ? ext_sel_b_i : ext_sel_a_i;
        ch_en_o    <= en_nx;
        sample_b_o <= use_b;
        eos_o      <= eos_nx;
      end
    end
  end
endmodule

// File: rtl/adc_chan_seq_chk.sv
module adc_chan_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned EXT_W = 2,
  localparam int unsigned SEL_W = $clog2(N_IN)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_i,
  input logic             cfg_we_i,
  input logic [CNT_W-1:0] chan_cnt_i,
  input logic             hires_i,
  input logic             scan_en_i,
  input logic             alt_en_i,
  input logic [N_IN-1:0]  scan_mask_i,
  input logic [SEL_W-1:0] sel_a_pos_i,
  input logic [SEL_W-1:0] ext_dummy_unused_i,
  input logic [EXT_W-1:0] ext_sel_a_i,
  input logic [SEL_W-1:0] ch0_sel_o,
  input logic [EXT_W-1:0] ext_sel_o,
  input logic [N_CH-1:0]  ch_en_o,
  input logic             sample_b_o,
  input logic             valid_o,
  input logic             eos_o
);
  logic             acc_d, cfg_d, hires_d, scan_d, alt_d;
  logic [CNT_W-1:0] cnt_d;
  logic [N_IN-1:0]  mask_d;
  logic [SEL_W-1:0] sel_a_d;
  logic [EXT_W-1:0] ext_a_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_d <= 1'b0; cfg_d <= 1'b0; hires_d <= 1'b0; scan_d <= 1'b0;
      alt_d <= 1'b0; cnt_d <= '0; mask_d <= '0; sel_a_d <= '0; ext_a_d <= '0;
    end else begin
      acc_d   <= trig_i & ~cfg_we_i;
      cfg_d   <= cfg_we_i;
      hires_d <= hires_i;
      scan_d  <= scan_en_i;
      alt_d   <= alt_en_i;
      cnt_d   <= chan_cnt_i;
      mask_d  <= scan_mask_i;
      sel_a_d <= sel_a_pos_i;
      ext_a_d <= ext_sel_a_i;
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_d |-> valid_o);
  assert_valid_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_d |-> !valid_o);
  assert_hold_outputs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_d |-> ($stable(ch0_sel_o) && $stable(ch_en_o) && $stable(eos_o)));
  assert_cfg_drops_trig_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_d |-> !valid_o);
  assert_hires_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && hires_d) |-> (ch_en_o == 4'b0001));
  assert_cnt_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cnt_d == CNT_W'(CNT_CH0)) |-> (ch_en_o == 4'b0001));
  assert_no_alt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !alt_d) |-> (!sample_b_o && ext_sel_o == ext_a_d));
  assert_scan_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !sample_b_o && scan_d && (mask_d != '0)) |-> mask_d[ch0_sel_o]);
  assert_empty_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !sample_b_o && (!scan_d || mask_d == '0)) |-> (ch0_sel_o == sel_a_d));
  assert_fixed_eos_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !alt_d && !scan_d) |-> eos_o);

  always_comb begin
    if (!rst_ni) assert_reset_quiet_R11: assert (!valid_o && !eos_o && ch_en_o == '0);
  end
endmodule

bind adc_chan_seq adc_chan_seq_chk #(.N_IN(N_IN), .EXT_W(EXT_W)) chk_i (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .trig_i             (trig_i),
  .cfg_we_i           (cfg_we_i),
  .chan_cnt_i         (chan_cnt_i),
  .hires_i            (hires_i),
  .scan_en_i          (scan_en_i),
  .alt_en_i           (alt_en_i),
  .scan_mask_i        (scan_mask_i),
  .sel_a_pos_i        (sel_a_pos_i),
  .ext_dummy_unused_i (sel_b_pos_i),
  .ext_sel_a_i        (ext_sel_a_i),
  .ch0_sel_o          (ch0_sel_o),
  .ext_sel_o          (ext_sel_o),
  .ch_en_o            (ch_en_o),
  .sample_b_o         (sample_b_o),
  .valid_o            (valid_o),
  .eos_o              (eos_o)
);

// File: tb/adc_chan_seq_tb_top.sv
module adc_chan_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trig_i = 1'b0, cfg_we_i = 1'b0;
  logic [1:0]  chan_cnt_i = '0;
  logic        hires_i = 1'b0, scan_en_i = 1'b0, alt_en_i = 1'b0;
  logic [15:0] scan_mask_i = '0;
  logic [3:0]  sel_a_pos_i = 4'd7, sel_b_pos_i = 4'd3;
  logic [1:0]  ext_sel_a_i = 2'd1, ext_sel_b_i = 2'd2;
  logic [3:0]  ch0_sel_o, ch_en_o;
  logic [1:0]  ext_sel_o;
  logic        sample_b_o, valid_o, eos_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  adc_chan_seq dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cfg();
    @(negedge clk_i); cfg_we_i = 1'b1;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  // one trigger; outputs checked at the following negedge
  task automatic conv(input string req, input logic [3:0] sel, input logic b, input logic eos);
    @(negedge clk_i); trig_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b0;
    check({req, " valid"}, valid_o, 1'b1);
    check({req, " sel"}, ch0_sel_o, sel);
    check({req, " sample_b"}, sample_b_o, b);
    check({req, " eos"}, eos_o, eos);
    check({req, " ext"}, ext_sel_o, b ? ext_sel_b_i : ext_sel_a_i);
  endtask

  task automatic t_reset();
    check("R11 valid", valid_o, 0);
    check("R11 sel", ch0_sel_o, 0);
    check("R11 en", ch_en_o, 0);
    check("R11 eos", eos_o, 0);
  endtask

  task automatic t_count();
    logic [3:0] exp_en [4] = '{4'b0001, 4'b0011, 4'b1111, 4'b1111};
    for (int c = 0; c < 4; c++) begin
      chan_cnt_i = 2'(c); hires_i = 1'b0;
      conv("R1", 4'd7, 1'b0, 1'b1);
      check("R1 ch_en", ch_en_o, exp_en[c]);
      hires_i = 1'b1;
      conv("R2", 4'd7, 1'b0, 1'b1);
      check("R2 ch_en", ch_en_o, 4'b0001);
    end
    hires_i = 1'b0; chan_cnt_i = 2'b00;
  endtask

  task automatic t_fixed_a();
    scan_en_i = 0; alt_en_i = 0; write_cfg();
    conv("R4", 4'd7, 0, 1);
    conv("R4", 4'd7, 0, 1);
    check("R8 pulse", valid_o, 1'b1);
    @(negedge clk_i);
    check("R8 single", valid_o, 1'b0);
    sel_a_pos_i = 4'd12;
    @(negedge clk_i);
    check("R8 hold", ch0_sel_o, 4'd7);
    sel_a_pos_i = 4'd7;
  endtask

  task automatic t_alt();
    alt_en_i = 1; write_cfg();
    conv("R5", 4'd7, 0, 0);
    conv("R5", 4'd3, 1, 1);
    conv("R5", 4'd7, 0, 0);
    conv("R5", 4'd3, 1, 1);
    conv("R7", 4'd7, 0, 0);
    write_cfg();
    conv("R7 toggle", 4'd7, 0, 0);
    alt_en_i = 0;
  endtask

  task automatic t_scan();
    scan_mask_i = 16'h8420; scan_en_i = 1; write_cfg();
    conv("R3", 4'd5, 0, 0);
    conv("R3", 4'd10, 0, 0);
    conv("R6", 4'd15, 0, 1);
    conv("R3 wrap", 4'd5, 0, 0);
    conv("R3", 4'd10, 0, 0);
    write_cfg();
    conv("R7 ptr", 4'd5, 0, 0);
  endtask

  task automatic t_scan_alt();
    alt_en_i = 1; write_cfg();
    conv("R5", 4'd5, 0, 0);
    conv("R5", 4'd3, 1, 0);
    conv("R5", 4'd10, 0, 0);
    conv("R5", 4'd3, 1, 0);
    conv("R5", 4'd15, 0, 0);
    conv("R6", 4'd3, 1, 1);
    conv("R5 wrap", 4'd5, 0, 0);
    alt_en_i = 0;
  endtask

  task automatic t_single_bit();
    scan_mask_i = 16'h0200; write_cfg();
    conv("R6 single", 4'd9, 0, 1);
    conv("R6 single", 4'd9, 0, 1);
  endtask

  task automatic t_empty();
    scan_mask_i = 16'h0000; write_cfg();
    conv("R9", 4'd7, 0, 1);
    conv("R9", 4'd7, 0, 1);
    scan_en_i = 0;
  endtask

  task automatic t_collide();
    scan_en_i = 1; scan_mask_i = 16'h0024; write_cfg();
    conv("R10 pre", 4'd2, 0, 0);
    @(negedge clk_i); trig_i = 1; cfg_we_i = 1;
    @(negedge clk_i); trig_i = 0; cfg_we_i = 0;
    check("R10 dropped", valid_o, 1'b0);
    check("R10 held", ch0_sel_o, 4'd2);
    conv("R10 restart", 4'd2, 0, 0);
    conv("R10 next", 4'd5, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_count();
    t_fixed_a();
    t_alt();
    t_scan();
    t_scan_alt();
    t_single_bit();
    t_empty();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule